// File: doc/BRIEF.md
# Condition Flag Compare Unit

This block executes the compare instructions of a 32-bit processor pipeline. It looks at the instruction word and the two source operands that the register file stage has already read. When the word is a well-formed compare, it evaluates the selected condition. The result lands in a one-bit condition flag register, which the branch logic reads.

Two instruction forms are recognised. The register form compares operand A with operand B. The immediate form compares operand A with a 16-bit immediate taken from the instruction word. Each form supports equality, inequality and the four ordered relations, and the ordered relations exist in both unsigned and signed flavours, selected by a dense 5-bit condition code. A compare never writes a general register; its only architectural effect is the flag.

A compare word with an unknown condition code, or with nonzero reserved bits, is reported on a registered error output one cycle later, and the flag keeps its value. Words of any other instruction class are ignored. The register index fields are decoded by the register file stage and play no part here.

Top module: `cmpf_unit`

## Requirements
- R1: After reset, `flag_o` is 0 and `illegal_o` is 0.
- R2: The register form is recognised when bits 31:30 are 3 and bits 29:26 are 9. It compares `src_a_i` with `src_b_i` and requires bits 10:0 to be zero.
- R3: The immediate form is recognised when bits 31:30 are 2 and bits 29:26 are 14. It compares `src_a_i` with the immediate in bits 15:0, and `src_b_i` is not used.
- R4: The condition code sits in bits 25:21. Code 0 sets the flag when the operands are equal, and code 1 sets it when they differ.
- R5: Codes 2, 3, 4 and 5 give the unsigned greater, greater-or-equal, less and less-or-equal relations of A against the second operand. In the immediate form their immediate is zero-extended.
- R6: Codes 6, 7, 8 and 9 give the same four relations in two's-complement signed order. In the immediate form their immediate is sign-extended.
- R7: With codes 0 and 1, the immediate of the immediate form is sign-extended before the comparison.
- R8: A valid compare word is illegal when its code is 10 to 31, or when it is a register form with a nonzero bit in 10:0. Such a word sets `illegal_o` to 1 in the following cycle and leaves `flag_o` unchanged.
- R9: A valid word of any other class leaves `flag_o` unchanged, and `illegal_o` is 0 in the following cycle.
- R10: The flag takes the compare result on the rising clock edge that samples `insn_valid_i` high with a legal compare. With `insn_valid_i` low, the flag holds and `illegal_o` is 0 in the next cycle, whatever the instruction word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| insn_valid_i | input | 1 | Instruction word and operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | DATA_W | Operand A from the register file |
| src_b_i | input | DATA_W | Operand B from the register file (register form only) |
| flag_o | output | 1 | Registered condition flag |
| illegal_o | output | 1 | One-cycle pulse for an illegal compare encoding |

## Verification
The bench builds the unit with the default DATA_W of 32, so the operand is twice the width of the immediate. With this width, sign extension of the immediate fills sixteen upper bits. Results that differ only through those bits are then reachable, for example an immediate of 0xFFFF against an A of 0xFFFFFFFF under the equal, unsigned and signed codes. The width also puts the signed and unsigned orders of 0x80000000 and 0x7FFFFFFF in direct conflict, and the bench drives that pair under every ordered code. Random compares in both forms are mixed with illegal codes, words with reserved bits set, foreign instruction classes and idle cycles, so that flag retention is checked after each kind of stimulus.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int CODE_W = 5;

  localparam logic [1:0] CLS_REG = 2'd3;
  localparam logic [3:0] SUB_REG = 4'd9;
  localparam logic [1:0] CLS_IMM = 2'd2;
  localparam logic [3:0] SUB_IMM = 4'd14;

  localparam int NUM_COND = 10;

  typedef enum logic [CODE_W-1:0] {
    C_EQ  = 5'd0,
    C_NE  = 5'd1,
    C_UGT = 5'd2,
    C_UGE = 5'd3,
    C_ULT = 5'd4,
    C_ULE = 5'd5,
    C_SGT = 5'd6,
    C_SGE = 5'd7,
    C_SLT = 5'd8,
    C_SLE = 5'd9
  } cond_e;

  typedef struct packed {
    logic              hit;       // word is a compare of either form
    logic              imm_form;  // immediate form selected
    logic              legal;     // code known and reserved bits clear
    logic              zext;      // immediate is zero-extended
    cond_e             cond;
    logic [IMM_W-1:0]  imm;
  } dec_s;
endpackage

// File: rtl/cmpf_rst_sync.sv
module cmpf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/cmpf_decode.sv
module cmpf_decode
  import cmpf_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_s              dec_o
);
  logic [1:0]        cls;
  logic [3:0]        sub;
  logic [CODE_W-1:0] code;
  logic              is_reg;
  logic              is_imm;
  logic              code_ok;
  logic              rsv_ok;

  always_comb begin
    cls     = insn_i[31:30];
    sub     = insn_i[29:26];
    code    = insn_i[25:21];
    is_reg  = (cls == CLS_REG) && (sub == SUB_REG);
    is_imm  = (cls == CLS_IMM) && (sub == SUB_IMM);
    code_ok = (32'(code) < NUM_COND);
    rsv_ok  = is_imm || (insn_i[10:0] == 11'd0);

    dec_o.hit      = is_reg || is_imm;
    dec_o.imm_form = is_imm;
    dec_o.legal    = code_ok && rsv_ok;
    dec_o.cond     = cond_e'(code);
    dec_o.zext     = (code >= 5'(C_UGT)) && (code <= 5'(C_ULE));
    dec_o.imm      = insn_i[IMM_W-1:0];
  end
endmodule

// File: rtl/cmpf_operand.sv
module cmpf_operand
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dec_s              dec_i,
  input  logic [DATA_W-1:0] rb_i,
  output logic [DATA_W-1:0] opb_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic             fill;
  logic [PAD_W-1:0] pad;

  always_comb begin
    fill = dec_i.zext ? 1'b0 : dec_i.imm[IMM_W-1];
    pad  = {PAD_W{fill}};
    if (dec_i.imm_form) opb_o = {pad, dec_i.imm};
    else                opb_o = rb_i;
  end
endmodule

// File: rtl/cmpf_eval.sv
module cmpf_eval
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cond_e             cond_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              res_o
);
  logic eq;
  logic ult;
  logic slt;

  always_comb begin
    eq  = (a_i == b_i);
    ult = (a_i < b_i);
    slt = ($signed(a_i) < $signed(b_i));
    unique case (cond_i)
      C_EQ:    res_o = eq;
      C_NE:    res_o = !eq;
      C_UGT:   res_o = !ult && !eq;
      C_UGE:   res_o = !ult;
      C_ULT:   res_o = ult;
      C_ULE:   res_o = ult || eq;
      C_SGT:   res_o = !slt && !eq;
      C_SGE:   res_o = !slt;
      C_SLT:   res_o = slt;
      C_SLE:   res_o = slt || eq;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpf_unit.sv
module cmpf_unit
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              flag_o,
  output logic              illegal_o
);
  logic              rst_q_n;
  dec_s              dec;
  logic [DATA_W-1:0] opb;
  logic              res;
  logic              fire;
  logic              flag_en;
  logic              flag_d;
  logic              flag_q;
  logic              ill_d;
  logic              ill_q;

  cmpf_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  cmpf_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  cmpf_operand #(.DATA_W(DATA_W)) u_opnd (
    .dec_i (dec),
    .rb_i  (src_b_i),
    .opb_o (opb)
  );

  cmpf_eval #(.DATA_W(DATA_W)) u_eval (
    .cond_i (dec.cond),
    .a_i    (src_a_i),
    .b_i    (opb),
    .res_o  (res)
  );

  // next state
  always_comb begin
    fire    = insn_valid_i && dec.hit;
    flag_en = fire && dec.legal;
    flag_d  = flag_en ? res : flag_q;
    ill_d   = fire && !dec.legal;
  end

  // state
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flag_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ill_q  <= ill_d;
    end
  end

  assign flag_o    = flag_q;
  assign illegal_o = ill_q;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !insn_valid_i |=> ($stable(flag_o) && !illegal_o));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal_o |-> $stable(flag_o));

  // R9
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (insn_valid_i && !dec.hit) |=> (!illegal_o && $stable(flag_o)));

  // R5
  uns_zext_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec.hit && dec.imm_form && dec.zext) |-> (opb[DATA_W-1:IMM_W] == '0));

  // R4
  eq_set_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (flag_en && dec.cond == C_EQ && src_a_i == opb) |=> flag_o);
endmodule

// File: tb/cmpf_unit_bench.sv
module cmpf_unit_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          insn_valid_i = 1'b0;
  logic [31:0]   insn_i = '0;
  logic [W-1:0]  src_a_i = '0;
  logic [W-1:0]  src_b_i = '0;
  logic          flag_o;
  logic          illegal_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  logic        exp_flag = 1'b0;

  always #5 clk = ~clk;

  cmpf_unit #(.DATA_W(W)) u_cmpf_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_valid_i (insn_valid_i),
    .insn_i       (insn_i),
    .src_a_i      (src_a_i),
    .src_b_i      (src_b_i),
    .flag_o       (flag_o),
    .illegal_o    (illegal_o)
  );

  function automatic logic [31:0] mk_reg(logic [4:0] c, logic [10:0] rsv);
    return {2'd3, 4'd9, c, 5'd3, 5'd4, rsv};
  endfunction

  function automatic logic [31:0] mk_imm(logic [4:0] c, logic [15:0] i);
    return {2'd2, 4'd14, c, 5'd7, i};
  endfunction

  function automatic logic [31:0] ext_imm(logic [4:0] c, logic [15:0] i);
    if (c >= 5'd2 && c <= 5'd5) return {16'h0000, i};
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic model(logic [4:0] c, logic [31:0] a, logic [31:0] b);
    case (c)
      5'd0: return a == b;
      5'd1: return a != b;
      5'd2: return a > b;
      5'd3: return a >= b;
      5'd4: return a < b;
      5'd5: return a <= b;
      5'd6: return $signed(a) > $signed(b);
      5'd7: return $signed(a) >= $signed(b);
      5'd8: return $signed(a) < $signed(b);
      default: return $signed(a) <= $signed(b);
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // drive one word at a negedge, check after the following posedge
  task automatic issue(logic v, logic [31:0] w, logic [31:0] a, logic [31:0] b, string tag);
    logic is_reg, is_imm, ok, exp_ill;
    is_reg = (w[31:30] == 2'd3) && (w[29:26] == 4'd9);
    is_imm = (w[31:30] == 2'd2) && (w[29:26] == 4'd14);
    ok     = (w[25:21] < 5'd10) && (is_imm || w[10:0] == 11'd0);
    exp_ill = v && (is_reg || is_imm) && !ok;
    if (v && (is_reg || is_imm) && ok)
      exp_flag = model(w[25:21], a, is_imm ? ext_imm(w[25:21], w[15:0]) : b);
    insn_valid_i = v;
    insn_i       = w;
    src_a_i      = a;
    src_b_i      = b;
    @(posedge clk);
    @(negedge clk);
    insn_valid_i = 1'b0;
    chk(tag, "flag", flag_o, exp_flag);
    chk(tag, "illegal", illegal_o, exp_ill);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "flag", flag_o, 1'b0);
    chk("R1", "illegal", illegal_o, 1'b0);

    // R2 register form, R4 equality
    issue(1, mk_reg(5'd0, 11'd0), 32'h1234_5678, 32'h1234_5678, "R4");
    issue(1, mk_reg(5'd1, 11'd0), 32'h1234_5678, 32'h1234_5678, "R4");
    issue(1, mk_reg(5'd1, 11'd0), 32'h0, 32'h1, "R2");
    // R5 / R6 conflict pair
    for (int c = 2; c < 10; c++) begin
      issue(1, mk_reg(5'(c), 11'd0), 32'h8000_0000, 32'h7FFF_FFFF, c < 6 ? "R5" : "R6");
      issue(1, mk_reg(5'(c), 11'd0), 32'h7FFF_FFFF, 32'h7FFF_FFFF, c < 6 ? "R5" : "R6");
    end
    // R3 immediate form ignores src_b_i
    issue(1, mk_imm(5'd0, 16'h0042), 32'h42, 32'hDEAD_BEEF, "R3");
    // R7 eq with all-ones immediate is sign-extended
    issue(1, mk_imm(5'd0, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, "R7");
    issue(1, mk_imm(5'd1, 16'hFFFF), 32'h0000_FFFF, 32'h0, "R7");
    // R5 zero extension: 0xFFFF unsigned is 65535
    issue(1, mk_imm(5'd3, 16'hFFFF), 32'h0000_FFFF, 32'h0, "R5");
    issue(1, mk_imm(5'd4, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, "R5");
    // R6 sign extension: 0xFFFF signed is -1
    issue(1, mk_imm(5'd8, 16'hFFFF), 32'h0, 32'h0, "R6");
    issue(1, mk_imm(5'd7, 16'h8000), 32'hFFFF_8000, 32'h0, "R6");

    // R8 illegal codes and reserved bits, flag held
    issue(1, mk_reg(5'd0, 11'd0), 32'h5, 32'h5, "R8");
    issue(1, mk_reg(5'd10, 11'd0), 32'h5, 32'h6, "R8");
    issue(1, mk_imm(5'd31, 16'h0), 32'h5, 32'h6, "R8");
    issue(1, mk_reg(5'd1, 11'h400), 32'h5, 32'h6, "R8");
    issue(1, mk_reg(5'd1, 11'h001), 32'h5, 32'h6, "R8");
    // R9 foreign classes
    issue(1, {2'd3, 4'd8, 26'h3FF_FFFF}, 32'h1, 32'h2, "R9");
    issue(1, {2'd2, 4'd13, 5'd1, 21'h0}, 32'h1, 32'h2, "R9");
    // R10 valid low with compare words present
    issue(0, mk_reg(5'd1, 11'd0), 32'h1, 32'h2, "R10");
    issue(0, mk_reg(5'd20, 11'd0), 32'h1, 32'h2, "R10");
    issue(1, mk_reg(5'd1, 11'd0), 32'h1, 32'h2, "R10");
    issue(0, mk_imm(5'd0, 16'h1), 32'h7, 32'h7, "R10");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [4:0]  c;
      logic [31:0] a, b, w;
      logic        v;
      string       tag;
      c = 5'($urandom_range(0, 9));
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      v = ($urandom_range(0, 7) != 0);
      tag = (c < 2) ? "R4" : (c < 6) ? "R5" : "R6";
      case ($urandom_range(0, 9))
        0: begin w = mk_reg(5'($urandom_range(10, 31)), 11'd0); tag = "R8"; end
        1: begin w = mk_reg(c, 11'($urandom_range(1, 2047))); tag = "R8"; end
        2: begin w = {2'd1, 30'($urandom)}; tag = "R9"; end
        3, 4, 5: begin
          w = mk_imm(c, 16'($urandom));
          if ($urandom_range(0, 3) == 0) w[15:0] = a[15:0];
          if (c < 2) tag = "R7";
        end
        default: w = mk_reg(c, 11'd0);
      endcase
      if (!v) tag = "R10";
      issue(v, w, a, b, tag);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule